// File: doc/BRIEF.md
# Supply Fault Status and Alert Logic

This block watches four power rails on behalf of a power-switch controller. For each rail it receives four inputs: a comparator flag that says the rail is under its power-bad level, a flag that says the pass device's gate is enhanced, a flag that says the switch is commanded on, and a current-sense code from a converter. From these inputs it keeps two kinds of bits. Live status bits show present conditions. Sticky fault bits latch events until software or a clear strobe removes them.

Power-bad detection is filtered. A rail counts as bad only after its comparator flag has stayed asserted for longer than a programmable number of cycles, and the last rail uses its own longer filter. While any rail is bad, the board-health output is released and the local reset is held low. When every rail has recovered, the health output is asserted again and the local reset follows the upstream reset. A per-rail power-bad fault is recorded only when that rail's gate is enhanced, so rails that are ramping up or down do not produce false faults. A current code above a small limit on a rail whose switch is off marks a shorted pass device.

An alert mask holds one enable per fault bit. The active-low alert output goes low while any enabled fault is set. Software reads and writes the status, fault and mask registers through a simple single-cycle register port.

Top module: `sfm_top`

## Requirements
- R1: After reset the status, fault and mask registers read zero, `alert_n` is 1, `health_n` is 0 and `local_rst_n` equals `up_rst_n`.
- R2: Rail i becomes power bad (status register address 0 bit 0) after `below_thr[i]` is sampled high on FILT_STD+1 consecutive clock edges, and not sooner. The last rail uses FILT_LAST instead of FILT_STD.
- R3: If `below_thr[i]` is sampled low at any edge, the filter for rail i restarts, and the power-bad state of rail i drops at that same edge.
- R4: While any rail is power bad, `health_n` is 1 and `local_rst_n` is 0. Otherwise `health_n` is 0 and `local_rst_n` equals `up_rst_n`.
- R5: Fault register (address 1) bit i, for i below NS, is set one edge after rail i is power bad with `gate_on[i]` high. A power-bad rail with its gate off leaves that bit at 0.
- R6: For any rail with `sw_on` low and a code greater than SHORT_LIM (default 7), status bit 1 and fault bit NS (bit 4) are set one edge later. A code equal to SHORT_LIM, or a rail with its switch on, sets neither bit.
- R7: Fault bits are sticky. A write to address 1 clears each bit written as 0 and keeps each bit written as 1. A `flt_clr` pulse clears all fault bits. A set condition present in the same cycle as a clear wins.
- R8: The mask register (address 2) uses the same bit layout as the fault register and resets to zero. `alert_n` is 0 exactly when some fault bit and its mask bit are both 1.
- R9: Writes to address 0 have no effect, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_thr | input | NS | Per-rail under-threshold comparator flags |
| gate_on | input | NS | Per-rail pass-device gate enhanced |
| sw_on | input | NS | Per-rail switch commanded on |
| isense | input | NS*ADC_W | Current codes, rail i at bits [i*ADC_W +: ADC_W] |
| up_rst_n | input | 1 | Upstream reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 fault, 2 mask) |
| reg_wdata | input | 8 | Register write data |
| flt_clr | input | 1 | Clear strobe for all fault bits |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| health_n | output | 1 | Board healthy, active low |
| local_rst_n | output | 1 | Local reset, active low |
| alert_n | output | 1 | Masked fault alert, active low |

## Verification
The bench builds the block with its default parameters: four rails, filters of 15 and 17 cycles, 8-bit codes and a short limit of 7. With these values both filter lengths can be checked edge by edge, a glitch one cycle short of the filter can be placed on a rail, and the code boundary between 7 and 8 can be driven directly. A five-bit fault register gives 32 mask values, so every mask value is checked against two different fault patterns.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    typedef enum logic [REG_AW-1:0] {
        ADR_STATUS = 2'd0,
        ADR_FAULT  = 2'd1,
        ADR_MASK   = 2'd2,
        ADR_SPARE  = 2'd3
    } reg_addr_e;

    // status register bit positions
    localparam int ST_PB    = 0;
    localparam int ST_SHORT = 1;
endpackage

// File: rtl/sfm_deglitch.sv
module sfm_deglitch #(
    parameter int LIM = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below,
    output logic pb
);
    localparam int CW = $clog2(LIM + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pb;
    } dg_t;

    dg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!below) begin
            st_d.cnt = '0;
            st_d.pb  = 1'b0;
        end else if (st_q.cnt == CW'(LIM)) begin
            st_d.pb = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pb = st_q.pb;
endmodule

// File: rtl/sfm_short_det.sv
module sfm_short_det #(
    parameter int ADC_W     = 8,
    parameter int SHORT_LIM = 7
) (
    input  logic             sw_on,
    input  logic [ADC_W-1:0] code,
    output logic             hit
);
    always_comb hit = !sw_on && (code > ADC_W'(SHORT_LIM));
endmodule

// File: rtl/sfm_regs.sv
module sfm_regs
    import sfm_pkg::*;
#(
    parameter int NS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NS-1:0]     pb,
    input  logic [NS-1:0]     gate_on,
    input  logic              short_any,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    input  logic              clr,
    output logic [REG_DW-1:0] rdata,
    output logic [NS:0]       fault,
    output logic [NS:0]       mask
);
    localparam int FW = NS + 1;

    typedef struct packed {
        logic [FW-1:0] fault;
        logic [FW-1:0] mask;
        logic          short_live;
    } rg_t;

    rg_t st_d, st_q;
    logic [FW-1:0] set_v;
    logic [REG_DW-1:0] status_v;

    always_comb begin
        set_v = {short_any, pb & gate_on};
        st_d  = st_q;
        if (wr && addr == ADR_FAULT) st_d.fault = st_q.fault & wdata[FW-1:0];
        if (wr && addr == ADR_MASK)  st_d.mask  = wdata[FW-1:0];
        if (clr)                     st_d.fault = '0;
        st_d.fault      = st_d.fault | set_v;
        st_d.short_live = short_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_v           = '0;
        status_v[ST_PB]    = |pb;
        status_v[ST_SHORT] = st_q.short_live;
        case (addr)
            ADR_STATUS: rdata = status_v;
            ADR_FAULT:  rdata = REG_DW'(st_q.fault);
            ADR_MASK:   rdata = REG_DW'(st_q.mask);
            default:    rdata = '0;
        endcase
    end

    assign fault = st_q.fault;
    assign mask  = st_q.mask;
endmodule

// File: rtl/sfm_top.sv
module sfm_top
    import sfm_pkg::*;
#(
    parameter int NS        = 4,
    parameter int FILT_STD  = 15,
    parameter int FILT_LAST = 17,
    parameter int ADC_W     = 8,
    parameter int SHORT_LIM = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NS-1:0]       below_thr,
    input  logic [NS-1:0]       gate_on,
    input  logic [NS-1:0]       sw_on,
    input  logic [NS*ADC_W-1:0] isense,
    input  logic                up_rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic                flt_clr,
    output logic [7:0]          reg_rdata,
    output logic                health_n,
    output logic                local_rst_n,
    output logic                alert_n
);
    logic [NS-1:0] pb_vec;
    logic [NS-1:0] short_hit;
    logic [NS:0]   fault_vec;
    logic [NS:0]   mask_vec;
    logic          short_any;
    logic          pb_any;

    for (genvar i = 0; i < NS; i++) begin : g_rail
        localparam int LIM_I = (i == NS - 1) ? FILT_LAST : FILT_STD;
        sfm_deglitch #(.LIM(LIM_I)) u_dg (
            .clk   (clk),
            .rst_n (rst_n),
            .below (below_thr[i]),
            .pb    (pb_vec[i])
        );
        sfm_short_det #(.ADC_W(ADC_W), .SHORT_LIM(SHORT_LIM)) u_sd (
            .sw_on (sw_on[i]),
            .code  (isense[i*ADC_W +: ADC_W]),
            .hit   (short_hit[i])
        );
    end

    assign short_any = |short_hit;
    assign pb_any    = |pb_vec;

    sfm_regs #(.NS(NS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pb        (pb_vec),
        .gate_on   (gate_on),
        .short_any (short_any),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .clr       (flt_clr),
        .rdata     (reg_rdata),
        .fault     (fault_vec),
        .mask      (mask_vec)
    );

    assign health_n    = pb_any;
    assign local_rst_n = pb_any ? 1'b0 : up_rst_n;
    assign alert_n     = ~|(fault_vec & mask_vec);
endmodule

// File: rtl/sfm_chk.sv
module sfm_chk #(
    parameter int NS        = 4,
    parameter int ADC_W     = 8,
    parameter int SHORT_LIM = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NS-1:0]       below_thr,
    input logic [NS-1:0]       gate_on,
    input logic [NS-1:0]       sw_on,
    input logic [NS*ADC_W-1:0] isense,
    input logic [NS-1:0]       pb_vec,
    input logic [NS:0]         fault_vec,
    input logic                reg_wr,
    input logic [1:0]          reg_addr,
    input logic                flt_clr,
    input logic                local_rst_n
);
    for (genvar i = 0; i < NS; i++) begin : g_c
        // R3
        pb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !below_thr[i] |=> !pb_vec[i]);
        // R2
        pb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pb_vec[i]) |-> $past(below_thr[i]));
        // R5
        gate_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fault_vec[i]) |-> $past(pb_vec[i] && gate_on[i]));
        // R6
        short_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!sw_on[i] && isense[i*ADC_W +: ADC_W] > ADC_W'(SHORT_LIM)) |=> fault_vec[NS]);
    end

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_vec && !flt_clr && !(reg_wr && reg_addr == 2'd1)) |=> ($past(fault_vec) & ~fault_vec) == '0);

    // R4
    local_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |pb_vec |-> !local_rst_n);
endmodule

bind sfm_top sfm_chk #(.NS(NS), .ADC_W(ADC_W), .SHORT_LIM(SHORT_LIM)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .below_thr   (below_thr),
    .gate_on     (gate_on),
    .sw_on       (sw_on),
    .isense      (isense),
    .pb_vec      (pb_vec),
    .fault_vec   (fault_vec),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .flt_clr     (flt_clr),
    .local_rst_n (local_rst_n)
);

// File: tb/sfm_top_tb_top.sv
module sfm_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4, ADC_W = 8, FS = 15, FL = 17;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NS-1:0] below_thr = '0, gate_on = '0, sw_on = '1;
    logic [NS*ADC_W-1:0] isense = '0;
    logic up_rst_n = 1'b1, reg_wr = 1'b0, flt_clr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic health_n, local_rst_n, alert_n;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfm_top dut_i (
        .clk(clk), .rst_n(rst_n), .below_thr(below_thr), .gate_on(gate_on),
        .sw_on(sw_on), .isense(isense), .up_rst_n(up_rst_n), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .flt_clr(flt_clr),
        .reg_rdata(reg_rdata), .health_n(health_n), .local_rst_n(local_rst_n),
        .alert_n(alert_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic clear_all();
        below_thr = '0; gate_on = '0; sw_on = '1; isense = '0;
        tick(1);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd0, d); check("R1 status", d, 0);
        rd(2'd1, d); check("R1 fault", d, 0);
        rd(2'd2, d); check("R1 mask", d, 0);
        check("R1 alert_n", alert_n, 1);
        check("R1 health_n", health_n, 0);
        check("R1 local_rst_n", local_rst_n, 1);
    endtask

    task automatic t_deglitch();
        logic [7:0] d;
        below_thr[0] = 1'b1;
        tick(FS);      rd(2'd0, d); check("R2 rail0 not yet", d[0], 0);
        tick(1);       rd(2'd0, d); check("R2 rail0 bad", d[0], 1);
        below_thr[0] = 1'b0; tick(1);
        rd(2'd0, d); check("R3 rail0 drop", d[0], 0);
        below_thr[3] = 1'b1;
        tick(FL);      rd(2'd0, d); check("R2 rail3 not yet", d[0], 0);
        tick(1);       rd(2'd0, d); check("R2 rail3 bad", d[0], 1);
        below_thr[3] = 1'b0; tick(1);
        rd(2'd1, d); check("R5 gate off no fault", d, 0);
    endtask

    task automatic t_glitch();
        logic [7:0] d;
        below_thr[2] = 1'b1; tick(FS);
        below_thr[2] = 1'b0; tick(1);
        below_thr[2] = 1'b1; tick(FS);
        rd(2'd0, d); check("R3 glitch restarts", d[0], 0);
        tick(1);     rd(2'd0, d); check("R3 full filter after glitch", d[0], 1);
        below_thr[2] = 1'b0; tick(1);
    endtask

    task automatic t_health();
        below_thr[1] = 1'b1; tick(FS + 1);
        check("R4 health released", health_n, 1);
        check("R4 local reset held", local_rst_n, 0);
        below_thr[1] = 1'b0; tick(1);
        check("R4 health back", health_n, 0);
        check("R4 reset follows hi", local_rst_n, 1);
        up_rst_n = 1'b0; #1;
        check("R4 reset follows lo", local_rst_n, 0);
        up_rst_n = 1'b1;
    endtask

    task automatic t_gate();
        logic [7:0] d;
        below_thr[1] = 1'b1; tick(FS + 3);
        rd(2'd1, d); check("R5 gate off", d, 0);
        gate_on[1] = 1'b1; tick(1);
        rd(2'd1, d); check("R5 gate on sets bit1", d, 8'h02);
        clear_all();
    endtask

    task automatic t_short();
        logic [7:0] d;
        sw_on[2] = 1'b0; isense[2*ADC_W +: ADC_W] = 8'd7; tick(1);
        rd(2'd0, d); check("R6 code7 status", d[1], 0);
        rd(2'd1, d); check("R6 code7 fault", d, 0);
        sw_on[2] = 1'b1; isense[2*ADC_W +: ADC_W] = 8'd255; tick(1);
        rd(2'd1, d); check("R6 switch on", d, 0);
        sw_on[2] = 1'b0; isense[2*ADC_W +: ADC_W] = 8'd8; tick(1);
        rd(2'd0, d); check("R6 code8 status", d[1], 1);
        rd(2'd1, d); check("R6 code8 fault", d, 8'h10);
        isense = '0; tick(1);
        rd(2'd0, d); check("R6 status live", d[1], 0);
        clear_all();
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        sw_on[0] = 1'b0; isense[0 +: ADC_W] = 8'd20; tick(1);
        isense = '0; tick(3);
        rd(2'd1, d); check("R7 sticky", d, 8'h10);
        wr(2'd1, 8'h1F); rd(2'd1, d); check("R7 write one keeps", d, 8'h10);
        wr(2'd1, 8'h0F); rd(2'd1, d); check("R7 write zero clears", d, 0);
        isense[0 +: ADC_W] = 8'd20; tick(1); isense = '0; tick(1);
        flt_clr = 1'b1; tick(1); flt_clr = 1'b0;
        rd(2'd1, d); check("R7 strobe clears", d, 0);
        isense[0 +: ADC_W] = 8'd20; flt_clr = 1'b1; tick(1); flt_clr = 1'b0;
        rd(2'd1, d); check("R7 set wins strobe", d, 8'h10);
        reg_addr = 2'd1; reg_wdata = 8'h00; reg_wr = 1'b1; tick(1); reg_wr = 1'b0;
        rd(2'd1, d); check("R7 set wins write", d, 8'h10);
        clear_all();
    endtask

    task automatic t_alert();
        logic [7:0] d;
        gate_on = '1; below_thr = '1; tick(FL + 3);
        below_thr = '0; gate_on = '0;
        sw_on[3] = 1'b0; isense[3*ADC_W +: ADC_W] = 8'd9; tick(1);
        sw_on = '1; isense = '0; tick(1);
        rd(2'd1, d); check("R8 all faults", d, 8'h1F);
        for (int m = 0; m < 32; m++) begin
            wr(2'd2, 8'(m));
            rd(2'd2, d); check("R8 mask readback", d, 32'(m));
            check("R8 alert all faults", alert_n, (m == 0) ? 1 : 0);
        end
        wr(2'd1, 8'h05);
        for (int m = 0; m < 32; m++) begin
            wr(2'd2, 8'(m)); #1;
            check("R8 alert pattern 05", alert_n, ((m & 5) == 0) ? 1 : 0);
        end
        clear_all();
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(2'd0, 8'hFF);
        rd(2'd0, d); check("R9 status write ignored", d, 0);
        rd(2'd1, d); check("R9 fault untouched", d, 0);
        rd(2'd2, d); check("R9 mask untouched", d, 0);
        rd(2'd3, d); check("R9 spare reads zero", d, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_deglitch();
        t_glitch();
        t_health();
        t_gate();
        t_short();
        t_sticky();
        t_alert();
        t_regs();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule